// File: doc/BRIEF.md
# Disk Buffer Sector Sequencer

This block walks a two-block sector buffer during a disk transfer. The host first records a track with a seek write, which sets the direction (read or write), the head and a 12-bit track number. The block then works out the zone and the linear start offset of that track. After that the host writes a control word. That word can arm a ping-pong to the other block, drop the mechanism interrupt, hold or release a sequencer reset, and start the run.

Each step of the sequencer does one of three things. It may emit one linear sector address on a valid/ready stream. It may count a C2 correction sector. It may decide whether to continue in the other block. The host acknowledges each transfer with a DMA to one of two fixed window addresses. Each acknowledge clears status flags and triggers the next step. A periodic tick retires the final interrupt once the counter has passed the end of the block.

The address stream follows these rules. `sa_valid` stays high and `sa_addr` stays stable until `sa_ready` is seen high at a clock edge. A step that is requested while an address is waiting is held back. The control-register and DMA side effects of the request still apply at once. Only one held step is kept. The held step runs in the first cycle the stream can take a new address. The host interrupt output is high while the mechanism interrupt or the buffer-manager interrupt is pending.

Top module: `dbm_sector_seq`

## Requirements
- R1: A control write copies `ctl_wdata[23:16]` into `cur_sector`. The value 0x00 sets `cur_blk` to 0 and `cur_cnt` to 0. The value 0x5A sets `cur_blk` to 1 and `cur_cnt` to 0. Any other value leaves `cur_blk` and `cur_cnt` unchanged.
- R2: Control bit 1 set makes `st_blk_pend` 1. Control bit 2 set clears `st_mecha`. A `mecha_set` pulse sets `st_mecha`, and it wins over a clear in the same cycle.
- R3: A control write with bit 3 set latches a reset hold and clears nothing. The next control write with bit 3 clear clears `st_bm_int`, `st_drq`, `st_c2`, `st_micro`, `st_blk_pend`, `st_running`, `cur_sector`, `cur_blk` and `cur_cnt`. This happens before any start in that same write.
- R4: Control bit 0 sets `st_running` and takes one step on the same write. Every step taken while running sets `st_bm_int`. A step while not running changes nothing. `irq` is high exactly when `st_mecha` or `st_bm_int` is 1.
- R5: In a read with `cur_cnt` below SPB, a step emits an address, increments `cur_cnt` and sets `st_drq`.
- R6: In a read with head 0, track 6 and `cur_sector` 0, a step emits nothing, clears `st_drq` and sets `st_micro`.
- R7: In a read, the four steps after the data sectors each increment `cur_cnt`. `st_c2` is set on the step that reaches SPB+4. The step after that works as follows: if `st_blk_pend` is 1, it toggles `cur_blk`, zeroes `cur_cnt` and clears `st_blk_pend`; otherwise it clears `st_running`.
- R8: In a write, a step with `cur_cnt` below SPB emits an address and sets `st_drq`. At `cur_cnt` equal to SPB, a step with the block pending toggles `cur_blk` and emits sector 0 of the new block. It then leaves `cur_cnt` at 1 and clears the pending flag. Without a pending block, the step makes `cur_cnt` SPB+1 and clears `st_running`.
- R9: The emitted address is: track offset + `cur_blk`·SPB·ZSIZE[zone] + sector·(`sec_bytes`+1).
- R10: The zone number is the count of edges in {0x09E, 0x13C, 0x1D1, 0x266, 0x2FB, 0x390, 0x425} that the track is at or above, plus 8 when head is 1. The track offset is ZSTART[zone] + (track − highest edge passed, or 0 if none)·ZSIZE[zone]·SPB·BPT.
- R11: A DMA to WIN_A (0x05000000) clears `st_bm_int` and `st_c2` and takes a step. A DMA to WIN_B (0x05000400) clears `st_bm_int` and `st_drq` and takes a step. A DMA to any other address has no effect.
- R12: On `tick`, if `st_bm_int` is 1 and `cur_cnt` is above SPB, `st_bm_int` clears and a step is taken. Otherwise the tick has no effect.
- R13: While `sa_valid` is 1 and `sa_ready` is 0, `sa_addr` holds and requested steps are deferred until the stream frees. Among events in one cycle, a control write beats a DMA, and a DMA beats a tick; the losing events are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seek_we | input | 1 | Record a new track |
| seek_dir_wr | input | 1 | Transfer direction, 1 = write |
| seek_head | input | 1 | Head select |
| seek_track | input | 12 | Track number |
| sec_bytes | input | 8 | Sector size field, the address stride minus one |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word: bit0 start, bit1 block transfer, bit2 mechanism interrupt clear, bit3 reset hold, bits 23:16 sector |
| dma_valid | input | 1 | DMA acknowledge strobe |
| dma_addr | input | 32 | DMA acknowledge address |
| tick | input | 1 | Periodic check strobe |
| mecha_set | input | 1 | Raises the mechanism interrupt |
| sa_valid | output | 1 | Sector address valid |
| sa_ready | input | 1 | Sector address accepted |
| sa_addr | output | 32 | Linear sector address |
| irq | output | 1 | Host interrupt |
| st_drq | output | 1 | Data request flag |
| st_c2 | output | 1 | C2 transfer flag |
| st_bm_int | output | 1 | Buffer-manager interrupt flag |
| st_mecha | output | 1 | Mechanism interrupt flag |
| st_micro | output | 1 | Micro status flag |
| st_running | output | 1 | Sequencer running |
| st_blk_pend | output | 1 | Block ping-pong pending |
| cur_blk | output | 1 | Current block index |
| cur_cnt | output | CW | Sector counter |
| cur_sector | output | 8 | Current sector register |

## Verification
The bench sweeps tracks on both sides of every zone edge, for both heads and several sector sizes. On each track it checks every emitted address across a full two-block read. A design that picked the zone off by one at an edge, or that did not add 8 for the head, would get the address wrong by a whole zone. The bench also checks the exact step at which C2 is raised and the ping-pong decision that follows. A sequencer that counted one C2 sector too few or too many would raise the flag early or late, or would switch blocks on the wrong acknowledge. Other tests cover the write-side decision, which emits sector 0 of the new block, and the track 6 micro path. Further tests check that a reset is held until released, that a tick does nothing before the counter passes SPB, that an unknown DMA address is ignored, and that a step waiting behind a stalled address is neither lost nor allowed to overwrite it.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int NZONE = 16;
  localparam int NEDGE = 7;
  typedef logic [11:0] trk_t;
  typedef logic [31:0] word_t;
  typedef word_t ztab_t [NZONE];
  // Zone boundaries on the track number, ascending
  localparam trk_t ZONE_EDGE [NEDGE] = '{12'h09E, 12'h13C, 12'h1D1, 12'h266,
                                         12'h2FB, 12'h390, 12'h425};
  localparam ztab_t DEF_ZSTART = '{32'h0000_0000, 32'h0080_0000, 32'h0100_0000, 32'h0180_0000,
                                   32'h0200_0000, 32'h0280_0000, 32'h0300_0000, 32'h0380_0000,
                                   32'h0400_0000, 32'h0480_0000, 32'h0500_0000, 32'h0580_0000,
                                   32'h0600_0000, 32'h0680_0000, 32'h0700_0000, 32'h0780_0000};
  localparam ztab_t DEF_ZSIZE = '{32'd232, 32'd216, 32'd208, 32'd192, 32'd176, 32'd160, 32'd144, 32'd128,
                                  32'd216, 32'd208, 32'd192, 32'd176, 32'd160, 32'd144, 32'd128, 32'd112};
  // Control word bit positions
  localparam int B_START = 0;
  localparam int B_BLKX  = 1;
  localparam int B_MRST  = 2;
  localparam int B_RST   = 3;
endpackage

// File: rtl/dbm_zone_map.sv
module dbm_zone_map
  import dbm_pkg::*;
#(
  parameter int    SPB    = 85,
  parameter int    BPT    = 2,
  parameter ztab_t ZSTART = DEF_ZSTART,
  parameter ztab_t ZSIZE  = DEF_ZSIZE
) (
  input  logic        head,
  input  trk_t        track,
  output logic [3:0]  zone,
  output word_t       trk_off
);
  localparam word_t TRK_SPAN = word_t'(SPB * BPT);

  logic [NEDGE-1:0] ge;
  logic [2:0]       lvl;
  trk_t             base;

  for (genvar g = 0; g < NEDGE; g++) begin : g_cmp
    assign ge[g] = (track >= ZONE_EDGE[g]);
  end

  always_comb begin
    lvl  = '0;
    base = '0;
    for (int i = 0; i < NEDGE; i++) begin
      if (ge[i]) begin
        lvl  = lvl + 3'd1;
        base = ZONE_EDGE[i];
      end
    end
    zone    = {head, lvl};
    trk_off = ZSTART[zone] + {20'd0, track - base} * ZSIZE[zone] * TRK_SPAN;
  end
endmodule

// File: rtl/dbm_addr_gen.sv
module dbm_addr_gen
  import dbm_pkg::*;
#(
  parameter int    SPB   = 85,
  parameter int    CW    = 7,
  parameter ztab_t ZSIZE = DEF_ZSIZE
) (
  input  word_t          trk_off,
  input  logic [3:0]     zone,
  input  logic           blk,
  input  logic [CW-1:0]  sec,
  input  logic [7:0]     sec_bytes,
  output word_t          addr
);
  word_t blk_span;
  word_t stride;

  always_comb begin
    blk_span = blk ? word_t'(SPB) * ZSIZE[zone] : '0;
    stride   = {24'd0, sec_bytes} + 32'd1;
    addr     = trk_off + blk_span + word_t'(sec) * stride;
  end
endmodule

// File: rtl/dbm_step_core.sv
module dbm_step_core
  import dbm_pkg::*;
#(
  parameter int    SPB   = 85,
  parameter int    CW    = 7,
  parameter word_t WIN_A = 32'h0500_0000,
  parameter word_t WIN_B = 32'h0500_0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  word_t         ctl_wdata,
  input  logic          dma_valid,
  input  word_t         dma_addr,
  input  logic          tick,
  input  logic          mecha_set,
  input  logic          dir_wr,
  input  logic          trk_is6,
  output logic          emit_blk,
  output logic [CW-1:0] emit_sec,
  input  word_t         emit_addr,
  output logic          sa_valid,
  input  logic          sa_ready,
  output word_t         sa_addr,
  output logic          st_drq,
  output logic          st_c2,
  output logic          st_bm_int,
  output logic          st_mecha,
  output logic          st_micro,
  output logic          st_running,
  output logic          st_blk_pend,
  output logic          cur_blk,
  output logic [CW-1:0] cur_cnt,
  output logic [7:0]    cur_sector
);
  localparam logic [CW-1:0] N_DATA = CW'(SPB);
  localparam logic [CW-1:0] N_C2   = CW'(SPB + 4);

  logic          hold_q, held_q;
  logic          n_drq, n_c2, n_bm, n_mecha, n_micro, n_run, n_pend, n_blk, n_hold, n_held;
  logic [CW-1:0] n_cnt;
  logic [7:0]    n_sec;
  logic          step_ev, want, go, emit;
  logic          unused_bits;

  assign unused_bits = ^{ctl_wdata[31:24], ctl_wdata[15:4]};

  always_comb begin
    n_drq = st_drq;   n_c2 = st_c2;       n_bm = st_bm_int;  n_mecha = st_mecha;
    n_micro = st_micro; n_run = st_running; n_pend = st_blk_pend;
    n_blk = cur_blk;  n_cnt = cur_cnt;    n_sec = cur_sector; n_hold = hold_q;
    step_ev = 1'b0;
    // Event stage: control write, else DMA window, else periodic check
    if (ctl_we) begin
      n_sec = ctl_wdata[23:16];
      if (n_sec == 8'h00) begin
        n_blk = 1'b0; n_cnt = '0;
      end else if (n_sec == 8'h5A) begin
        n_blk = 1'b1; n_cnt = '0;
      end
      if (ctl_wdata[B_BLKX]) n_pend = 1'b1;
      if (ctl_wdata[B_MRST]) n_mecha = 1'b0;
      if (ctl_wdata[B_RST]) begin
        n_hold = 1'b1;
      end else if (hold_q) begin
        n_hold = 1'b0;
        n_bm = 1'b0; n_drq = 1'b0; n_c2 = 1'b0; n_micro = 1'b0;
        n_pend = 1'b0; n_run = 1'b0; n_sec = '0; n_blk = 1'b0; n_cnt = '0;
      end
      if (ctl_wdata[B_START]) begin
        n_run = 1'b1; step_ev = 1'b1;
      end
    end else if (dma_valid && dma_addr == WIN_A) begin
      n_bm = 1'b0; n_c2 = 1'b0; step_ev = 1'b1;
    end else if (dma_valid && dma_addr == WIN_B) begin
      n_bm = 1'b0; n_drq = 1'b0; step_ev = 1'b1;
    end else if (tick && st_bm_int && cur_cnt > N_DATA) begin
      n_bm = 1'b0; step_ev = 1'b1;
    end
    if (mecha_set) n_mecha = 1'b1;

    // Step stage: runs when the address stream can take a new entry
    want     = step_ev | held_q;
    go       = want && (!sa_valid || sa_ready);
    n_held   = want && !go;
    emit     = 1'b0;
    emit_blk = n_blk;
    emit_sec = n_cnt;
    if (go && n_run) begin
      n_bm = 1'b1;
      if (dir_wr) begin
        if (n_cnt < N_DATA) begin
          emit = 1'b1; n_cnt = n_cnt + 1'b1; n_drq = 1'b1;
        end else if (n_cnt == N_DATA) begin
          if (n_pend) begin
            n_blk = ~n_blk; emit_blk = n_blk; emit_sec = '0; emit = 1'b1;
            n_cnt = CW'(1); n_pend = 1'b0; n_drq = 1'b1;
          end else begin
            n_cnt = n_cnt + 1'b1; n_run = 1'b0;
          end
        end
      end else begin
        if (trk_is6 && n_sec == 8'h00) begin
          n_drq = 1'b0; n_micro = 1'b1;
        end else if (n_cnt < N_DATA) begin
          emit = 1'b1; n_cnt = n_cnt + 1'b1; n_drq = 1'b1;
        end else if (n_cnt < N_C2) begin
          n_cnt = n_cnt + 1'b1;
          if (n_cnt == N_C2) n_c2 = 1'b1;
        end else if (n_cnt == N_C2) begin
          if (n_pend) begin
            n_blk = ~n_blk; n_cnt = '0; n_pend = 1'b0;
          end else begin
            n_run = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_drq <= 1'b0; st_c2 <= 1'b0; st_bm_int <= 1'b0; st_mecha <= 1'b0;
      st_micro <= 1'b0; st_running <= 1'b0; st_blk_pend <= 1'b0;
      cur_blk <= 1'b0; cur_cnt <= '0; cur_sector <= '0;
      hold_q <= 1'b0; held_q <= 1'b0;
      sa_valid <= 1'b0; sa_addr <= '0;
    end else begin
      st_drq <= n_drq; st_c2 <= n_c2; st_bm_int <= n_bm; st_mecha <= n_mecha;
      st_micro <= n_micro; st_running <= n_run; st_blk_pend <= n_pend;
      cur_blk <= n_blk; cur_cnt <= n_cnt; cur_sector <= n_sec;
      hold_q <= n_hold; held_q <= n_held;
      if (emit) begin
        sa_valid <= 1'b1;
        sa_addr  <= emit_addr;
      end else if (sa_ready) begin
        sa_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbm_sector_seq.sv
module dbm_sector_seq
  import dbm_pkg::*;
#(
  parameter int    SPB    = 85,
  parameter int    BPT    = 2,
  parameter ztab_t ZSTART = DEF_ZSTART,
  parameter ztab_t ZSIZE  = DEF_ZSIZE,
  parameter word_t WIN_A  = 32'h0500_0000,
  parameter word_t WIN_B  = 32'h0500_0400,
  localparam int   CW     = $clog2(SPB + 6)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seek_we,
  input  logic          seek_dir_wr,
  input  logic          seek_head,
  input  logic [11:0]   seek_track,
  input  logic [7:0]    sec_bytes,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  input  logic          dma_valid,
  input  logic [31:0]   dma_addr,
  input  logic          tick,
  input  logic          mecha_set,
  output logic          sa_valid,
  input  logic          sa_ready,
  output logic [31:0]   sa_addr,
  output logic          irq,
  output logic          st_drq,
  output logic          st_c2,
  output logic          st_bm_int,
  output logic          st_mecha,
  output logic          st_micro,
  output logic          st_running,
  output logic          st_blk_pend,
  output logic          cur_blk,
  output logic [CW-1:0] cur_cnt,
  output logic [7:0]    cur_sector
);
  logic          dir_q, head_q;
  trk_t          trk_q;
  logic [3:0]    zone_d, zone_q;
  word_t         off_d, off_q;
  logic          emit_blk;
  logic [CW-1:0] emit_sec;
  word_t         emit_addr;

  dbm_zone_map #(.SPB(SPB), .BPT(BPT), .ZSTART(ZSTART), .ZSIZE(ZSIZE)) u_zone (
    .head(seek_head), .track(seek_track), .zone(zone_d), .trk_off(off_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0; head_q <= 1'b0; trk_q <= '0; zone_q <= '0; off_q <= '0;
    end else if (seek_we) begin
      dir_q <= seek_dir_wr; head_q <= seek_head; trk_q <= seek_track;
      zone_q <= zone_d; off_q <= off_d;
    end
  end

  dbm_addr_gen #(.SPB(SPB), .CW(CW), .ZSIZE(ZSIZE)) u_addr (
    .trk_off(off_q), .zone(zone_q), .blk(emit_blk), .sec(emit_sec),
    .sec_bytes(sec_bytes), .addr(emit_addr)
  );

  dbm_step_core #(.SPB(SPB), .CW(CW), .WIN_A(WIN_A), .WIN_B(WIN_B)) u_core (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .tick(tick), .mecha_set(mecha_set),
    .dir_wr(dir_q), .trk_is6(!head_q && trk_q == 12'd6),
    .emit_blk(emit_blk), .emit_sec(emit_sec), .emit_addr(emit_addr),
    .sa_valid(sa_valid), .sa_ready(sa_ready), .sa_addr(sa_addr),
    .st_drq(st_drq), .st_c2(st_c2), .st_bm_int(st_bm_int), .st_mecha(st_mecha),
    .st_micro(st_micro), .st_running(st_running), .st_blk_pend(st_blk_pend),
    .cur_blk(cur_blk), .cur_cnt(cur_cnt), .cur_sector(cur_sector)
  );

  assign irq = st_mecha | st_bm_int;
endmodule

// File: rtl/dbm_sector_seq_chk.sv
module dbm_sector_seq_chk #(
  parameter int          SPB   = 85,
  parameter int          CW    = 7,
  parameter logic [31:0] WIN_B = 32'h0500_0400
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [31:0]   ctl_wdata,
  input logic          dma_valid,
  input logic [31:0]   dma_addr,
  input logic          mecha_set,
  input logic          sa_valid,
  input logic          sa_ready,
  input logic [31:0]   sa_addr,
  input logic          st_drq,
  input logic          st_c2,
  input logic          st_bm_int,
  input logic          st_mecha,
  input logic          st_running,
  input logic [CW-1:0] cur_cnt
);
  localparam logic [CW-1:0] C2_AT = CW'(SPB + 4);

  // R7: the counter never runs past the C2 limit plus the write tail
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= C2_AT);

  // R7: C2 flag rises only when the counter sits at SPB+4
  p_c2_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_c2) |-> cur_cnt == C2_AT);

  // R13: a stalled address is held
  p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sa_valid && !sa_ready |=> sa_valid && $stable(sa_addr));

  // R2: mechanism clear bit drops the flag when not set in the same cycle
  p_mrst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[2] && !mecha_set |=> !st_mecha);

  // R11: data window acknowledge while idle leaves request and interrupt low
  p_winb_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && dma_addr == WIN_B && !ctl_we && !st_running |=> !st_drq && !st_bm_int);
endmodule

bind dbm_sector_seq dbm_sector_seq_chk #(.SPB(SPB), .CW(CW), .WIN_B(WIN_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .dma_valid(dma_valid), .dma_addr(dma_addr), .mecha_set(mecha_set),
  .sa_valid(sa_valid), .sa_ready(sa_ready), .sa_addr(sa_addr),
  .st_drq(st_drq), .st_c2(st_c2), .st_bm_int(st_bm_int), .st_mecha(st_mecha),
  .st_running(st_running), .cur_cnt(cur_cnt)
);

// File: tb/sim_dbm_sector_seq.sv
module sim_dbm_sector_seq;
  localparam int SPB = 5;
  localparam int BPT = 2;
  localparam int CW  = $clog2(SPB + 6);
  localparam logic [31:0] WA = 32'h0500_0000;
  localparam logic [31:0] WB = 32'h0500_0400;
  localparam logic [31:0] C_START = 32'h1, C_BLKX = 32'h2, C_MRST = 32'h4, C_RST = 32'h8;
  localparam logic [31:0] TS [16] = '{32'h0000_1000, 32'h0002_0000, 32'h0004_0000, 32'h0006_0000,
                                      32'h0008_0000, 32'h000A_0000, 32'h000C_0000, 32'h000E_0000,
                                      32'h0010_0000, 32'h0012_0000, 32'h0014_0000, 32'h0016_0000,
                                      32'h0018_0000, 32'h001A_0000, 32'h001C_0000, 32'h001E_0000};
  localparam logic [31:0] TZ [16] = '{32'd40, 32'd38, 32'd36, 32'd34, 32'd32, 32'd30, 32'd28, 32'd26,
                                      32'd39, 32'd37, 32'd35, 32'd33, 32'd31, 32'd29, 32'd27, 32'd25};
  localparam int EDG [7] = '{158, 316, 465, 614, 763, 912, 1061};

  logic clk = 0, rst_n = 0;
  logic seek_we = 0, seek_dir_wr = 0, seek_head = 0;
  logic [11:0] seek_track = 0;
  logic [7:0] sec_bytes = 0;
  logic ctl_we = 0; logic [31:0] ctl_wdata = 0;
  logic dma_valid = 0; logic [31:0] dma_addr = 0;
  logic tick = 0, mecha_set = 0, sa_ready = 1;
  logic sa_valid, irq, st_drq, st_c2, st_bm_int, st_mecha, st_micro, st_running, st_blk_pend, cur_blk;
  logic [31:0] sa_addr;
  logic [CW-1:0] cur_cnt;
  logic [7:0] cur_sector;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbm_sector_seq #(.SPB(SPB), .BPT(BPT), .ZSTART(TS), .ZSIZE(TZ), .WIN_A(WA), .WIN_B(WB)) u0 (
    .clk(clk), .rst_n(rst_n), .seek_we(seek_we), .seek_dir_wr(seek_dir_wr), .seek_head(seek_head),
    .seek_track(seek_track), .sec_bytes(sec_bytes), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .tick(tick), .mecha_set(mecha_set),
    .sa_valid(sa_valid), .sa_ready(sa_ready), .sa_addr(sa_addr), .irq(irq),
    .st_drq(st_drq), .st_c2(st_c2), .st_bm_int(st_bm_int), .st_mecha(st_mecha),
    .st_micro(st_micro), .st_running(st_running), .st_blk_pend(st_blk_pend),
    .cur_blk(cur_blk), .cur_cnt(cur_cnt), .cur_sector(cur_sector));

  function automatic logic [31:0] exp_addr(bit hd, int trk, int blk, int sec, int ss);
    int lvl; int base; int z;
    lvl = 0; base = 0;
    for (int i = 0; i < 7; i++) if (trk >= EDG[i]) begin lvl = i + 1; base = EDG[i]; end
    z = lvl + (hd ? 8 : 0);
    return TS[z] + 32'(trk - base) * TZ[z] * 32'(SPB * BPT) + 32'(blk * SPB) * TZ[z] + 32'(sec * (ss + 1));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(logic [31:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic ack(logic [31:0] a);
    @(negedge clk); dma_valid = 1; dma_addr = a;
    @(negedge clk); dma_valid = 0;
  endtask
  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask
  task automatic seek(bit wr, bit hd, int trk);
    @(negedge clk); seek_we = 1; seek_dir_wr = wr; seek_head = hd; seek_track = 12'(trk);
    @(negedge clk); seek_we = 0;
  endtask
  task automatic clean();
    ctl(C_RST); ctl(32'h0);
  endtask

  task automatic run_read(bit hd, int trk, int ss);
    sec_bytes = 8'(ss);
    seek(0, hd, trk); clean();
    ctl(C_START | C_BLKX);
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < SPB; s++) begin
        if (b == 1 || s > 0) ack(WB);
        chk("R9 R10 read addr", {31'd0, sa_valid}, 32'd1);
        chk("R9 R10 read addr", sa_addr, exp_addr(hd, trk, b, s, ss));
      end
      chk("R5 drq", {31'd0, st_drq}, 32'd1);
      for (int k = 1; k <= 4; k++) begin
        ack(WB);
        chk("R7 c2 timing", {31'd0, st_c2}, (k == 4) ? 32'd1 : 32'd0);
      end
      ack(WA);
      if (b == 0) begin
        chk("R7 toggle blk", {31'd0, cur_blk}, 32'd1);
        chk("R7 zero cnt", 32'(cur_cnt), 32'd0);
        chk("R7 pend cleared", {31'd0, st_blk_pend}, 32'd0);
      end else begin
        chk("R7 running cleared", {31'd0, st_running}, 32'd0);
      end
    end
    ack(WA);
    chk("R4 irq idle", {31'd0, irq}, 32'd0);
  endtask

  task automatic run_write(bit hd, int trk, int ss);
    sec_bytes = 8'(ss);
    seek(1, hd, trk); clean();
    ctl(32'h005A_0000 | C_START | C_BLKX);
    for (int s = 0; s < SPB; s++) begin
      if (s > 0) ack(WB);
      chk("R8 R9 write addr blk1", sa_addr, exp_addr(hd, trk, 1, s, ss));
      if (s == 0) begin
        tk();
        chk("R12 tick early ignored", {31'd0, st_bm_int}, 32'd1);
        chk("R12 tick early cnt", 32'(cur_cnt), 32'd1);
      end
    end
    ack(WB);
    chk("R8 toggle emit", {31'd0, sa_valid}, 32'd1);
    chk("R8 toggle addr", sa_addr, exp_addr(hd, trk, 0, 0, ss));
    chk("R8 cnt after toggle", 32'(cur_cnt), 32'd1);
    for (int s = 1; s < SPB; s++) begin
      ack(WB);
      chk("R8 R9 write addr blk0", sa_addr, exp_addr(hd, trk, 0, s, ss));
    end
    ack(WB);
    chk("R8 tail cnt", 32'(cur_cnt), 32'(SPB + 1));
    chk("R8 tail stop", {31'd0, st_running}, 32'd0);
    chk("R8 tail bm_int", {31'd0, st_bm_int}, 32'd1);
    tk();
    chk("R12 tick clears", {31'd0, st_bm_int}, 32'd0);
    chk("R4 irq drop", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset irq", {31'd0, irq}, 32'd0);
    chk("R13 reset valid", {31'd0, sa_valid}, 32'd0);
    chk("R4 reset running", {31'd0, st_running}, 32'd0);

    // Read sweep across zone edges, both heads
    for (int hd = 0; hd < 2; hd++)
      for (int i = 0; i < 8; i++) begin
        run_read(hd[0], (i == 0) ? 0 : EDG[i-1], (i * 37 + hd * 11) % 256);
        if (i < 7) run_read(hd[0], EDG[i] - 1, 255 - i * 19);
      end
    run_read(1, 4095, 3);

    for (int i = 0; i < 8; i++) run_write(i[0], (i == 0) ? 7 : EDG[i-1] + 3, i * 29);

    // R6: track 6 sector 0 read
    sec_bytes = 8'd9;
    seek(0, 0, 6); clean();
    ctl(C_START);
    chk("R6 micro", {31'd0, st_micro}, 32'd1);
    chk("R6 no emit", {31'd0, sa_valid}, 32'd0);
    chk("R6 drq low", {31'd0, st_drq}, 32'd0);
    chk("R4 bm_int on step", {31'd0, st_bm_int}, 32'd1);
    clean();
    ctl(32'h005A_0000 | C_START);
    chk("R6 other sector emits", sa_addr, exp_addr(0, 6, 1, 0, 9));
    chk("R1 cur_sector", 32'(cur_sector), 32'h5A);

    // R1: other sector value keeps counter and block
    ctl(32'h0033_0000);
    chk("R1 other sector copied", 32'(cur_sector), 32'h33);
    chk("R1 cnt kept", 32'(cur_cnt), 32'd1);
    chk("R1 blk kept", {31'd0, cur_blk}, 32'd1);

    // R11: unknown DMA address ignored
    ack(32'h0500_0800);
    chk("R11 ignored cnt", 32'(cur_cnt), 32'd1);
    chk("R11 ignored bm_int", {31'd0, st_bm_int}, 32'd1);
    chk("R11 ignored drq", {31'd0, st_drq}, 32'd1);

    // R3: hold then release
    ctl(C_RST | C_BLKX);
    chk("R3 hold keeps drq", {31'd0, st_drq}, 32'd1);
    chk("R2 pend set", {31'd0, st_blk_pend}, 32'd1);
    ctl(32'h0011_0000);
    chk("R3 release drq", {31'd0, st_drq}, 32'd0);
    chk("R3 release bm_int", {31'd0, st_bm_int}, 32'd0);
    chk("R3 release running", {31'd0, st_running}, 32'd0);
    chk("R3 release pend", {31'd0, st_blk_pend}, 32'd0);
    chk("R3 release sector", 32'(cur_sector), 32'd0);
    chk("R3 release cnt", 32'(cur_cnt), 32'd0);
    chk("R3 release blk", {31'd0, cur_blk}, 32'd0);

    // R2: mechanism interrupt
    @(negedge clk); mecha_set = 1; @(negedge clk); mecha_set = 0;
    chk("R2 R4 mecha irq", {31'd0, irq}, 32'd1);
    @(negedge clk); mecha_set = 1; ctl_we = 1; ctl_wdata = C_MRST | 32'h0011_0000;
    @(negedge clk); mecha_set = 0; ctl_we = 0;
    chk("R2 set wins", {31'd0, st_mecha}, 32'd1);
    ctl(C_MRST | 32'h0011_0000);
    chk("R2 mecha cleared", {31'd0, st_mecha}, 32'd0);
    chk("R4 irq low", {31'd0, irq}, 32'd0);

    // R13: back-pressure
    sec_bytes = 8'd4;
    seek(0, 0, 200); clean();
    @(negedge clk); sa_ready = 0;
    ctl(C_START);
    chk("R13 first addr", sa_addr, exp_addr(0, 200, 0, 0, 4));
    ack(WB);
    chk("R13 held addr", sa_addr, exp_addr(0, 200, 0, 0, 4));
    chk("R13 held valid", {31'd0, sa_valid}, 32'd1);
    chk("R13 step deferred", 32'(cur_cnt), 32'd1);
    chk("R11 drq cleared", {31'd0, st_drq}, 32'd0);
    sa_ready = 1;
    @(negedge clk);
    chk("R13 deferred emit", sa_addr, exp_addr(0, 200, 0, 1, 4));
    chk("R13 deferred cnt", 32'(cur_cnt), 32'd2);
    // R13: control write beats DMA in same cycle
    @(negedge clk); ctl_we = 1; ctl_wdata = 32'h0033_0000; dma_valid = 1; dma_addr = WB;
    @(negedge clk); ctl_we = 0; dma_valid = 0;
    chk("R13 priority cnt", 32'(cur_cnt), 32'd2);
    chk("R13 priority drq", {31'd0, st_drq}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule